// File: doc/BRIEF.md
# Calibrated Code to Millivolt Converter

This block turns raw 10-bit converter codes into signed millivolt values. Seven calibration bytes, each with its own valid flag, hold two-point calibration codes for three channel groups: a main charger voltage group, a temperature-sensor group and a battery voltage group. The code fields of these groups are bit-packed across byte boundaries. A load request captures the bytes, unpacks each group's high and low codes, and computes a per-group gain and offset with a shared multi-cycle divider.

A convert request carries a channel identifier and a code. For a calibrated group the result is (code*gain + offset)/1000. A group whose calibration bytes are incomplete, or whose codes cannot define a slope, falls back to a fixed nominal range. Several other channels always use a fixed linear range. Each conversion ends with a single-cycle done pulse, and unknown identifiers raise an error flag.

Top module: `cal_mv_conv`

## Requirements
- R1: After reset, busy, done and err are low, result is zero, and every group is uncalibrated, so all channels use their linear formula until a load completes.
- R2: With byte k at cal_bytes[8k+7:8k], the main codes are high = {b0[1:0], b1[5:0], b2[7:6]} and low = b2[5:1]. The temperature codes are high = {b2[0], b3[7:0], b4[7]} and low = b4[6:2]. The battery codes are high = {b4[1:0], b5[7:0]} and low = b6[7:2].
- R3: On a load, each valid group gets gain = floor(1000*(Vh-Vl)/(high-low)) and offset = 1000*Vh - gain*high. The reference points (Vh/Vl in mV) are 19500/315 for main, 1300/21 for temperature and 4700/2380 for battery.
- R4: A calibrated conversion returns (code*gain + offset)/1000, truncated toward zero. Done rises ACC_W+1 clock edges after the edge that accepts start.
- R5: A group is uncalibrated when any of its bytes is flagged invalid: bytes 0..2 for main, 2..4 for temperature and 4..6 for battery. Its channels then return min + (max-min)*code/1024, with ranges 0–20030 (main), 0–1350 (temperature) and 2300–4800 (battery).
- R6: A group whose high code is not greater than its low code is treated as uncalibrated.
- R7: The fixed-range channels return min + (max-min)*code/1024 with these ranges: die temperature (7) 0–1350, second accessory detect (8) 0–2500, bus voltage (9) 0–20030, main charger current (10) 0–1500, USB charger current (11) 0–1500, backup battery (12) 0–3200.
- R8: Channel identifiers map to groups as follows: 0 uses the main group, 1 to 5 use the temperature group, and 6 uses the battery group.
- R9: Identifiers 13 to 15 produce err high together with done, and a zero result, on the edge that accepts start.
- R10: Done is high for exactly one cycle per accepted conversion. A linear or unknown conversion raises it on the accepting edge itself.
- R11: Start is ignored while busy, including during a load. When cal_load and start are sampled together, the load wins and the start is dropped.
- R12: Offset and result are signed 32-bit values, so a negative scaled value is returned in two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_load | input | 1 | Capture calibration bytes and start computing gains |
| cal_bytes | input | 56 | Seven packed calibration bytes, byte k at [8k+7:8k] |
| cal_valid | input | 7 | Per-byte valid flag |
| start | input | 1 | Convert request |
| chan_id | input | 4 | Channel identifier |
| code | input | 10 | Raw converter code |
| busy | output | 1 | Load or conversion in progress |
| done | output | 1 | One-cycle pulse when result is valid |
| err | output | 1 | Unknown channel, pulses with done |
| result | output | 32 | Signed millivolt result |

## Verification
The hardest case to reach is a negative result. It needs an offset below zero, which happens only when the high and low calibration codes make Vh*low exceed Vl*high. The bench therefore packs contrived calibration bytes (main 200/31, battery 100/63) and converts code 0 and small codes. Other hard cases are a start that arrives in the middle of a divider run, and a start that arrives during a load. The bench raises start at chosen cycles inside the busy window and checks done on every cycle, to show that no extra pulse appears.

// File: rtl/cmv_pkg.sv
package cmv_pkg;
  localparam int CODE_W = 10;
  localparam logic [1:0] GRP_NONE = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_LGRP, S_LDIV, S_CDIV} cmv_state_e;

  typedef struct packed {
    logic        known;
    logic [1:0]  grp;
    logic [15:0] lo_mv;
    logic [15:0] span_mv;
  } chan_info_t;

  function automatic chan_info_t mk(input logic k, input logic [1:0] g,
                                    input logic [15:0] lo, input logic [15:0] span);
    chan_info_t c;
    c.known = k; c.grp = g; c.lo_mv = lo; c.span_mv = span;
    return c;
  endfunction

  function automatic chan_info_t chan_map(input logic [3:0] id);
    case (id)
      4'd0:                      return mk(1'b1, 2'd0, 16'd0, 16'd20030);
      4'd1, 4'd2, 4'd3, 4'd4, 4'd5: return mk(1'b1, 2'd1, 16'd0, 16'd1350);
      4'd6:                      return mk(1'b1, 2'd2, 16'd2300, 16'd2500);
      4'd7:                      return mk(1'b1, GRP_NONE, 16'd0, 16'd1350);
      4'd8:                      return mk(1'b1, GRP_NONE, 16'd0, 16'd2500);
      4'd9:                      return mk(1'b1, GRP_NONE, 16'd0, 16'd20030);
      4'd10, 4'd11:              return mk(1'b1, GRP_NONE, 16'd0, 16'd1500);
      4'd12:                     return mk(1'b1, GRP_NONE, 16'd0, 16'd3200);
      default:                   return mk(1'b0, GRP_NONE, 16'd0, 16'd0);
    endcase
  endfunction

  function automatic logic [15:0] ref_hi(input logic [1:0] g);
    case (g)
      2'd0:    return 16'd19500;
      2'd1:    return 16'd1300;
      default: return 16'd4700;
    endcase
  endfunction

  function automatic logic [15:0] ref_lo(input logic [1:0] g);
    case (g)
      2'd0:    return 16'd315;
      2'd1:    return 16'd21;
      default: return 16'd2380;
    endcase
  endfunction
endpackage

// File: rtl/cmv_unpack.sv
module cmv_unpack (
  input  logic [55:0]      bytes_i,
  input  logic [6:0]       valid_i,
  output logic [3:0][9:0]  hi_o,
  output logic [3:0][5:0]  lo_o,
  output logic [3:0]       ok_o
);
  logic [6:0][7:0] b;
  logic unused_bits;
  assign b = bytes_i;
  assign unused_bits = ^{b[0][7:2], b[1][7:6], b[6][1:0]};

  // bit-packed two-point fields (R2)
  always_comb begin
    hi_o[0] = {b[0][1:0], b[1][5:0], b[2][7:6]};
    lo_o[0] = {1'b0, b[2][5:1]};
    hi_o[1] = {b[2][0], b[3], b[4][7]};
    lo_o[1] = {1'b0, b[4][6:2]};
    hi_o[2] = {b[4][1:0], b[5]};
    lo_o[2] = b[6][7:2];
    hi_o[3] = '0;
    lo_o[3] = '0;
  end

  // group g owns bytes 2g..2g+2; neighbours share the end bytes (R5, R6)
  for (genvar g = 0; g < 3; g++) begin : g_ok
    assign ok_o[g] = (&valid_i[2*g+2 : 2*g]) && (hi_o[g] > {4'b0, lo_o[g]});
  end
  assign ok_o[3] = 1'b0;
endmodule

// File: rtl/cmv_divider.sv
module cmv_divider #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt;
  logic          run;
  logic [W-1:0]  dvs, dnd;
  logic [W:0]    shifted;

  assign shifted = {remainder, quotient[W-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0; run <= 1'b0; done <= 1'b0;
      dvs <= '0; dnd <= '0; quotient <= '0; remainder <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        remainder <= '0;
        quotient  <= dividend;
        dvs       <= divisor;
        dnd       <= dividend;
        cnt       <= CW'(W);
        run       <= 1'b1;
      end else if (run) begin
        if (shifted >= {1'b0, dvs}) begin
          remainder <= W'(shifted - {1'b0, dvs});
          quotient  <= {quotient[W-2:0], 1'b1};
        end else begin
          remainder <= shifted[W-1:0];
          quotient  <= {quotient[W-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_DIV_EXACT: assert property (@(posedge clk) disable iff (rst) done |-> (({{W{1'b0}}, quotient} * {{W{1'b0}}, dvs} + {{W{1'b0}}, remainder}) == {{W{1'b0}}, dnd}) && (remainder < dvs)); // R4
  AST_DIV_ONESHOT: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R10
endmodule

// File: rtl/cal_mv_conv.sv
module cal_mv_conv #(
  parameter int ACC_W  = 40,
  parameter int RES_W  = 32,
  parameter int SCALE  = 1000,
  parameter int LIN_SH = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cal_load,
  input  logic [55:0]      cal_bytes,
  input  logic [6:0]       cal_valid,
  input  logic             start,
  input  logic [3:0]       chan_id,
  input  logic [9:0]       code,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [RES_W-1:0] result
);
  import cmv_pkg::*;

  cmv_state_e state_q;
  logic [1:0]  g_q;
  logic        neg_q;
  logic [55:0] byt_q;
  logic [6:0]  vld_q;
  logic [RES_W-1:0]        gain_q [4];
  logic signed [RES_W-1:0] off_q  [4];

  logic [3:0][9:0] hi;
  logic [3:0][5:0] lo;
  logic [3:0]      ok;

  cmv_unpack u_unp (.bytes_i(byt_q), .valid_i(vld_q), .hi_o(hi), .lo_o(lo), .ok_o(ok));

  chan_info_t              info;
  logic                    use_cal, accept, div_go, div_done;
  logic [RES_W-1:0]        lin_mv, new_off;
  logic signed [ACC_W-1:0] num_s;
  logic [ACC_W-1:0]        num_mag, div_a, div_b, div_q, div_rem_unused;

  always_comb begin
    info    = chan_map(chan_id);
    use_cal = info.known && (info.grp != GRP_NONE) && (gain_q[info.grp] != '0);
    lin_mv  = RES_W'(info.lo_mv) +
              RES_W'((ACC_W'(info.span_mv) * ACC_W'(code)) >> LIN_SH);
    num_s   = $signed(ACC_W'(code)) * $signed(ACC_W'(gain_q[info.grp])) +
              ACC_W'(off_q[info.grp]);
    num_mag = num_s[ACC_W-1] ? ACC_W'(-num_s) : ACC_W'(num_s);
    accept  = (state_q == S_IDLE) && !cal_load && start;
    div_go  = (accept && use_cal) || ((state_q == S_LGRP) && ok[g_q]);
    if (state_q == S_LGRP) begin
      div_a = ACC_W'(SCALE * (int'(ref_hi(g_q)) - int'(ref_lo(g_q))));
      div_b = ACC_W'(hi[g_q] - {4'b0, lo[g_q]});
    end else begin
      div_a = num_mag;
      div_b = ACC_W'(SCALE);
    end
    new_off = RES_W'(ACC_W'(SCALE) * ACC_W'(ref_hi(g_q)) - div_q * ACC_W'(hi[g_q]));
  end

  cmv_divider #(.W(ACC_W)) u_div (
    .clk(clk), .rst(rst), .go(div_go), .dividend(div_a), .divisor(div_b),
    .done(div_done), .quotient(div_q), .remainder(div_rem_unused)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE; g_q <= '0; neg_q <= 1'b0;
      byt_q <= '0; vld_q <= '0;
      done <= 1'b0; err <= 1'b0; result <= '0;
      for (int i = 0; i < 4; i++) begin
        gain_q[i] <= '0;
        off_q[i]  <= '0;
      end
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (cal_load) begin
            byt_q <= cal_bytes; vld_q <= cal_valid; g_q <= '0;
            state_q <= S_LGRP;
          end else if (start) begin
            if (!info.known) begin
              err <= 1'b1; done <= 1'b1; result <= '0;
            end else if (use_cal) begin
              neg_q   <= num_s[ACC_W-1];
              state_q <= S_CDIV;
            end else begin
              result <= lin_mv; done <= 1'b1;
            end
          end
        end
        S_LGRP: begin
          if (ok[g_q]) state_q <= S_LDIV;
          else begin
            gain_q[g_q] <= '0;
            off_q[g_q]  <= '0;
            if (g_q == 2'd2) state_q <= S_IDLE;
            else g_q <= g_q + 2'd1;
          end
        end
        S_LDIV: if (div_done) begin
          gain_q[g_q] <= div_q[RES_W-1:0];
          off_q[g_q]  <= $signed(new_off);
          if (g_q == 2'd2) state_q <= S_IDLE;
          else begin
            g_q <= g_q + 2'd1;
            state_q <= S_LGRP;
          end
        end
        S_CDIV: if (div_done) begin
          result  <= neg_q ? RES_W'(-div_q[RES_W-1:0]) : div_q[RES_W-1:0];
          done    <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy = (state_q != S_IDLE);

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R10
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (rst) err |-> (done && result == '0)); // R9
  AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $past(start || cal_load)); // R11
endmodule

// File: tb/sim_cal_mv_conv.sv
module sim_cal_mv_conv;
  localparam int ACC_W   = 40;
  localparam int LAT_CAL = ACC_W + 1;

  logic clk = 1'b0, rst = 1'b1;
  logic cal_load = 1'b0, start = 1'b0;
  logic [55:0] cal_bytes = '0;
  logic [6:0]  cal_valid = '0;
  logic [3:0]  chan_id = '0;
  logic [9:0]  code = '0;
  logic busy, done, err;
  logic [31:0] result;

  int nchk = 0, nerr = 0;
  longint mg[3], mo[3];
  longint vh[3] = '{19500, 1300, 4700};
  longint vl[3] = '{315, 21, 2380};

  always #10 clk = ~clk;

  cal_mv_conv #(.ACC_W(ACC_W)) u0 (
    .clk(clk), .rst(rst), .cal_load(cal_load), .cal_bytes(cal_bytes),
    .cal_valid(cal_valid), .start(start), .chan_id(chan_id), .code(code),
    .busy(busy), .done(done), .err(err), .result(result)
  );

  task automatic chk(input bit cond, input string req, input longint act, input longint exp);
    nchk++;
    if (!cond) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [55:0] pack(input int mh, input int ml, input int th,
                                        input int tl, input int bh, input int bl);
    logic [6:0][7:0] b;
    logic [9:0] m, t, v;
    m = 10'(mh); t = 10'(th); v = 10'(bh);
    b = '0;
    b[0][1:0] = m[9:8];
    b[1][5:0] = m[7:2];
    b[2] = {m[1:0], 5'(ml), t[9]};
    b[3] = t[8:1];
    b[4] = {t[0], 5'(tl), v[9:8]};
    b[5] = v[7:0];
    b[6] = {6'(bl), 2'b00};
    return b;
  endfunction

  function automatic void model(input int ch, input int cd, output longint v,
                                output bit e, output bit cal);
    int grp = -1;
    longint mn = 0, mx = 0;
    e = 0; cal = 0; v = 0;
    case (ch)
      0: begin grp = 0; mx = 20030; end
      1, 2, 3, 4, 5: begin grp = 1; mx = 1350; end
      6: begin grp = 2; mn = 2300; mx = 4800; end
      7: mx = 1350;
      8: mx = 2500;
      9: mx = 20030;
      10, 11: mx = 1500;
      12: mx = 3200;
      default: e = 1;
    endcase
    if (e) return;
    if (grp >= 0 && mg[grp] != 0) begin
      cal = 1;
      v = (longint'(cd) * mg[grp] + mo[grp]) / 1000;
    end else
      v = mn + (mx - mn) * longint'(cd) / 1024;
  endfunction

  task automatic conv(input int ch, input int cd, input string req,
                      input int inj_ch = -1, input int inj_at = -1);
    longint exp_v, got = 0;
    bit exp_e, cal, gerr = 0, timing_ok = 1;
    int lat;
    model(ch, cd, exp_v, exp_e, cal);
    lat = cal ? LAT_CAL : 0;
    @(negedge clk);
    start = 1'b1; chan_id = 4'(ch); code = 10'(cd);
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n <= lat + 2; n++) begin
      if (n == inj_at) begin
        start = 1'b1; chan_id = 4'(inj_ch); code = 10'd1;
      end else start = 1'b0;
      if (done !== (n == lat)) timing_ok = 0;
      if (n == lat) begin
        got = longint'($signed(result));
        gerr = err;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(timing_ok, {req, " done pulse timing"}, lat, lat);
    chk(got == exp_v && gerr == exp_e, {req, " result"}, got, exp_v);
  endtask

  task automatic load(input logic [55:0] bytes, input logic [6:0] vld);
    bit stray = 0;
    for (int g = 0; g < 3; g++) begin
      int hi, lo;
      logic [6:0][7:0] b;
      b = bytes;
      case (g)
        0: begin hi = {b[0][1:0], b[1][5:0], b[2][7:6]}; lo = b[2][5:1]; end
        1: begin hi = {b[2][0], b[3], b[4][7]}; lo = b[4][6:2]; end
        default: begin hi = {b[4][1:0], b[5]}; lo = b[6][7:2]; end
      endcase
      if ((&vld[2*g +: 3]) && hi > lo) begin
        mg[g] = 1000 * (vh[g] - vl[g]) / (hi - lo);
        mo[g] = 1000 * vh[g] - mg[g] * hi;
      end else begin
        mg[g] = 0; mo[g] = 0;
      end
    end
    @(negedge clk);
    cal_load = 1'b1; cal_bytes = bytes; cal_valid = vld;
    @(negedge clk);
    cal_load = 1'b0;
    start = 1'b1; chan_id = 4'd7; code = 10'd100;  // R11: start during load
    chk(busy == 1'b1, "R11 busy after load", busy, 1);
    @(negedge clk);
    start = 1'b0;
    while (busy) begin
      if (done) stray = 1;
      @(negedge clk);
    end
    if (done) stray = 1;
    chk(!stray, "R11 start ignored during load", stray, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    for (int g = 0; g < 3; g++) begin mg[g] = 0; mo[g] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !err && result == 0, "R1 reset outputs", result, 0);
    conv(0, 512, "R1 main before load");
    conv(6, 0, "R5 battery before load");

    load(pack(997, 16, 985, 16, 982, 33), 7'h7f);
    conv(0, 997, "R2 main high point");
    conv(0, 16, "R4 main low point");
    conv(1, 500, "R8 battery control");
    conv(2, 985, "R8 battery temperature");
    conv(3, 0, "R8 accessory detect 1");
    conv(4, 1023, "R8 aux 1");
    conv(5, 300, "R8 aux 2");
    conv(6, 982, "R4 battery high");
    conv(6, 33, "R3 battery low");
    conv(7, 1023, "R7 die temperature");
    conv(8, 512, "R7 accessory detect 2");
    conv(9, 1023, "R7 bus voltage");
    conv(10, 100, "R7 main charger current");
    conv(11, 1023, "R7 usb charger current");
    conv(12, 700, "R7 backup battery");
    conv(13, 5, "R9 unknown 13");
    conv(15, 1023, "R9 unknown 15");
    conv(0, 700, "R11 start during conversion", 7, 5);

    load(pack(997, 16, 985, 16, 982, 33), 7'b1101111);
    conv(0, 500, "R5 main still calibrated");
    conv(2, 500, "R5 temperature fallback");
    conv(6, 500, "R5 battery fallback");
    load(pack(997, 16, 985, 16, 982, 33), 7'b1111011);
    conv(0, 500, "R5 main fallback");
    conv(1, 400, "R5 temperature fallback shared byte");
    conv(6, 500, "R5 battery calibrated");

    load(pack(20, 20, 10, 12, 982, 33), 7'h7f);
    conv(0, 400, "R6 equal codes");
    conv(1, 400, "R6 high below low");
    conv(6, 400, "R6 battery unaffected");

    load(pack(200, 31, 985, 16, 100, 63), 7'h7f);
    conv(0, 0, "R12 negative main");
    conv(6, 0, "R12 negative battery");
    conv(6, 10, "R12 battery small code");

    begin
      bit seen = 0;
      @(negedge clk);
      cal_load = 1'b1; start = 1'b1; chan_id = 4'd7; code = 10'd50;
      cal_bytes = pack(997, 16, 985, 16, 982, 33); cal_valid = 7'h7f;
      @(negedge clk);
      cal_load = 1'b0; start = 1'b0;
      chk(busy && !done, "R11 load wins over start", done, 0);
      while (busy) begin
        if (done) seen = 1;
        @(negedge clk);
      end
      chk(!seen && !done, "R11 dropped start makes no done", seen, 0);
      for (int g = 0; g < 3; g++) begin
        mg[g] = 1000 * (vh[g] - vl[g]) / (g == 0 ? 981 : g == 1 ? 969 : 949);
      end
      mo[0] = 1000 * vh[0] - mg[0] * 997;
      mo[1] = 1000 * vh[1] - mg[1] * 985;
      mo[2] = 1000 * vh[2] - mg[2] * 982;
      conv(0, 800, "R3 reload gain");
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule